// File: doc/BRIEF.md
# Multiplexed Eight-Digit Seven-Segment Driver

This block lights an eight-digit seven-segment display whose segment lines are shared by all digits. It does this by time multiplexing. A clock-enable divider running on the system clock issues one scan tick per scan period. Each tick moves a scan index to the next digit position. For the current index, the block drives exactly one anode low. It also places that position's BCD digit, converted to active-low segment levels, on the shared cathode bus.

The decimal point serves as an edit cursor. It is lit under the digit at the cursor position, but only while the edit-mode input is high. The surrounding logic supplies the eight digits, the cursor and the edit flag. This block neither stores nor changes them.

The scan period in system clock cycles is `2*(CLK_HZ/(2*SCAN_HZ))`. With the default 50 MHz clock and 1 kHz scan rate, that is 50,000 cycles per digit slot.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted, and after it until the first scan tick, all anode bits and all cathode bits are 1, so the display is dark.
- R2: The first scan tick after reset release occurs on the cycle ending at clock edge number PERIOD, where PERIOD = 2*(CLK_HZ/(2*SCAN_HZ) - 1 + 1). Later ticks follow every PERIOD cycles, and two ticks are never adjacent.
- R3: The scan index starts at 0 on the first tick. It advances by exactly one per later tick and wraps from 7 back to 0.
- R4: When lit, `anode_n` has bit i equal to 0 for scan index i, and every other bit equal to 1. At no time is more than one anode bit 0.
- R5: Cathode bits 0 to 6 carry segments A to G, active low. They show the digit held in `digits_bcd[4*i+3:4*i]` for scan index i. Codes 0 to 9 use the usual segment shapes.
- R6: Digit codes 10 to 15 turn all seven segments off (bits 0 to 6 equal 1).
- R7: Cathode bit 7 (decimal point, active low) is 0 only when `edit_mode` is 1 and `cursor_pos` equals the scan index.
- R8: When `edit_mode` is 0, cathode bit 7 stays 1 whatever the cursor value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digits_bcd | input | 32 | Eight 4-bit digit codes, position i in bits [4i+3:4i] |
| cursor_pos | input | 3 | Position of the edit cursor |
| edit_mode | input | 1 | High when the cursor may be shown |
| anode_n | output | 8 | Digit enables, active low |
| seg_n | output | 8 | Segments A to G in bits 0 to 6, decimal point in bit 7, active low |

## Verification
The bench builds the block with CLK_HZ = 16000 and SCAN_HZ = 1000, which makes the scan period 16 cycles. With a period that short, the dark interval before the first tick, the exact tick edge, every slot, and a full 7-to-0 wrap are all covered within a few hundred cycles. The production default of 50,000 cycles per slot would put those events far out of reach. The divider count, index width and decoder are otherwise unchanged, so the same structure runs at a small count limit.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

   localparam int SEG_LINES = 7;
   localparam int BCD_W     = 4;

   typedef logic [SEG_LINES-1:0] seg_shape_t;

   // Active-high segment shape, bit 0 = A ... bit 6 = G; non-decimal codes blank
   function automatic seg_shape_t bcd_shape(input logic [BCD_W-1:0] code);
      seg_shape_t s;
      case (code)
         4'd0:    s = 7'b011_1111;
         4'd1:    s = 7'b000_0110;
         4'd2:    s = 7'b101_1011;
         4'd3:    s = 7'b100_1111;
         4'd4:    s = 7'b110_0110;
         4'd5:    s = 7'b110_1101;
         4'd6:    s = 7'b111_1101;
         4'd7:    s = 7'b000_0111;
         4'd8:    s = 7'b111_1111;
         4'd9:    s = 7'b110_1111;
         default: s = 7'b000_0000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
   parameter int PERIOD = 50000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (PERIOD < 1) begin : g_bad
         $error("scan_tick_gen: PERIOD must be at least 1");
      end else if (PERIOD == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(PERIOD);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)              cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);

         assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick)
            else $error("scan ticks adjacent");
      end
   endgenerate

endmodule

// File: rtl/scan_index_ctr.sv
module scan_index_ctr #(
   parameter int POSITIONS = 8,
   localparam int IDX_W = (POSITIONS > 1) ? $clog2(POSITIONS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic             live,
   output logic [IDX_W-1:0] idx
);

   generate
      if ((1 << IDX_W) != POSITIONS) begin : g_bad
         $error("scan_index_ctr: POSITIONS must be a power of two for natural wrap");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         live <= 1'b0;
         idx  <= '0;
      end else if (tick) begin
         if (!live) live <= 1'b1;
         else       idx  <= idx + 1'b1;
      end
   end

   assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
      (tick && live) |=> (idx == IDX_W'($past(idx) + 1'b1)))
      else $error("scan index did not advance by one");

   assert_idx_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!tick && live) |=> $stable(idx))
      else $error("scan index moved without a tick");

endmodule

// File: rtl/seg_frame_build.sv
module seg_frame_build
   import seg_scan_pkg::*;
#(
   parameter int POSITIONS = 8,
   localparam int IDX_W = (POSITIONS > 1) ? $clog2(POSITIONS) : 1
) (
   input  logic [POSITIONS*BCD_W-1:0] digits,
   input  logic [IDX_W-1:0]           idx,
   input  logic [IDX_W-1:0]           cursor,
   input  logic                       edit,
   input  logic                       live,
   output logic [POSITIONS-1:0]       anode_n,
   output logic [SEG_LINES:0]         seg_n
);

   logic [BCD_W-1:0] slot_code [POSITIONS];
   logic [POSITIONS-1:0] sel_hot;

   generate
      for (genvar g = 0; g < POSITIONS; g++) begin : g_slot
         assign slot_code[g] = digits[g*BCD_W +: BCD_W];
         assign sel_hot[g]   = live && (idx == IDX_W'(g));
      end
   endgenerate

   logic [BCD_W-1:0] cur_code;
   logic             dot_on;

   always_comb begin
      cur_code = slot_code[idx];
      dot_on   = live && edit && (cursor == idx);
      anode_n  = ~sel_hot;
      if (live) seg_n[SEG_LINES-1:0] = ~bcd_shape(cur_code);
      else      seg_n[SEG_LINES-1:0] = '1;
      seg_n[SEG_LINES] = ~dot_on;
   end

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
   import seg_scan_pkg::*;
#(
   parameter int CLK_HZ    = 50_000_000,
   parameter int SCAN_HZ   = 1000,
   parameter int POSITIONS = 8,
   localparam int IDX_W     = (POSITIONS > 1) ? $clog2(POSITIONS) : 1,
   localparam int DIV_VALUE = CLK_HZ / (2 * SCAN_HZ) - 1,
   localparam int PERIOD    = 2 * (DIV_VALUE + 1)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [POSITIONS*BCD_W-1:0] digits_bcd,
   input  logic [IDX_W-1:0]           cursor_pos,
   input  logic                       edit_mode,
   output logic [POSITIONS-1:0]       anode_n,
   output logic [SEG_LINES:0]         seg_n
);

   generate
      if (SCAN_HZ < 1 || CLK_HZ < 2 * SCAN_HZ) begin : g_bad_rate
         $error("seg_scan_driver: CLK_HZ must be at least twice SCAN_HZ");
      end
   endgenerate

   logic             scan_tick;
   logic             scan_live;
   logic [IDX_W-1:0] scan_idx;

   scan_tick_gen #(.PERIOD(PERIOD)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (scan_tick)
   );

   scan_index_ctr #(.POSITIONS(POSITIONS)) u_idx (
      .clk  (clk),
      .rst  (rst),
      .tick (scan_tick),
      .live (scan_live),
      .idx  (scan_idx)
   );

   seg_frame_build #(.POSITIONS(POSITIONS)) u_frame (
      .digits  (digits_bcd),
      .idx     (scan_idx),
      .cursor  (cursor_pos),
      .edit    (edit_mode),
      .live    (scan_live),
      .anode_n (anode_n),
      .seg_n   (seg_n)
   );

   assert_one_anode_R4: assert property (@(posedge clk) disable iff (rst)
      $countones(~anode_n) <= 1)
      else $error("more than one anode enabled");

   assert_dark_before_tick_R1: assert property (@(posedge clk) disable iff (rst)
      !scan_live |-> (&anode_n && &seg_n))
      else $error("display lit before first scan tick");

   assert_dot_masked_R8: assert property (@(posedge clk) disable iff (rst)
      !edit_mode |-> seg_n[SEG_LINES])
      else $error("decimal point lit outside edit mode");

endmodule

// File: tb/seg_scan_driver_bench.sv
module seg_scan_driver_bench;

   localparam int CLK_HZ  = 16000;
   localparam int SCAN_HZ = 1000;
   localparam int P       = 2 * (CLK_HZ / (2 * SCAN_HZ));
   localparam int N       = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] digits_bcd = '0;
   logic [2:0]  cursor_pos = '0;
   logic        edit_mode  = 1'b0;
   logic [7:0]  anode_n;
   logic [7:0]  seg_n;

   always #2 clk = ~clk;

   seg_scan_driver #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ), .POSITIONS(N)) u_seg_scan_driver (
      .clk        (clk),
      .rst        (rst),
      .digits_bcd (digits_bcd),
      .cursor_pos (cursor_pos),
      .edit_mode  (edit_mode),
      .anode_n    (anode_n),
      .seg_n      (seg_n)
   );

   typedef struct {
      int         edge_no;
      logic [7:0] an;
      logic [7:0] sg;
      string      tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad   = 0;
   int edge_count = 0;
   int wd = 0;
   bit done = 0;

   always @(posedge clk) begin
      if (rst) edge_count <= 0;
      else     edge_count <= edge_count + 1;
   end

   function automatic logic [6:0] shape(input logic [3:0] c);
      case (c)
         4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
         4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
         4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
         4'd9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] an, input logic [7:0] sg,
                        input logic [7:0] ean, input logic [7:0] esg);
      total++;
      if (an !== ean || sg !== esg) begin
         bad++;
         $display("FAIL %s anode=%h expected %h seg=%h expected %h", tag, an, ean, sg, esg);
      end
   endtask

   // monitor: compare at the negedge following the scheduled posedge
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].edge_no == edge_count) begin
         check(q[0].tag, anode_n, seg_n, q[0].an, q[0].sg);
         void'(q.pop_front());
      end
   end

   // driver: schedule n slot midpoints with expectations from current inputs
   task automatic run_slots(input int n, input string tag);
      int base = ((edge_count / P) + 1) * P + P / 2;
      for (int i = 0; i < n; i++) begin
         item_t it;
         int s;
         it.edge_no = base + i * P;
         s = ((it.edge_no / P) - 1) % N;
         it.an = ~(8'd1 << s);
         it.sg = {~(edit_mode && cursor_pos == 3'(s)), ~shape(digits_bcd[4*s +: 4])};
         it.tag = tag;
         q.push_back(it);
      end
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset", anode_n, seg_n, 8'hFF, 8'hFF);
      digits_bcd = 32'h6295_1413;  // pos0=3 pos1=1 pos2=4 pos3=1 pos4=5 pos5=9 pos6=2 pos7=6
      cursor_pos = 3'd2;
      edit_mode  = 1'b1;
      @(negedge clk);
      check("R1 reset inputs", anode_n, seg_n, 8'hFF, 8'hFF);
      rst = 1'b0;
      // R1/R2: dark on the edge before the first tick, lit slot 0 on edge P
      begin
         item_t a, b;
         a.edge_no = P - 1; a.an = 8'hFF; a.sg = 8'hFF; a.tag = "R1 R2 dark before tick";
         b.edge_no = P;     b.an = 8'hFE; b.sg = {1'b1, ~shape(4'd3)}; b.tag = "R2 first slot";
         q.push_back(a); q.push_back(b);
         wait (q.size() == 0);
         @(negedge clk);
      end
      // R3 R4 R5 R7: all slots plus wrap back to 0
      run_slots(9, "R3 R4 R5 R7 scan");
      // R8: cursor masked when not editing
      edit_mode = 1'b0;
      run_slots(8, "R8 masked");
      // R6 R7: blank codes with cursor on last position
      digits_bcd = 32'h8FED_CBA0;
      cursor_pos = 3'd7;
      edit_mode  = 1'b1;
      run_slots(8, "R6 R7 blank");
      // R5 R7: cursor moves to position 0, other digits
      digits_bcd = 32'h0123_4578;
      cursor_pos = 3'd0;
      run_slots(4, "R5 R7 cursor0");
      done = 1;
   end

   initial begin
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hang expected=finish");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule